// File: doc/BRIEF.md
# Command Packet Header Validator

This block sits behind a serial receiver and takes in 24-bit words one at a time through a valid/data stream. It keeps them in a 32-slot ring. The oldest word in the ring is always treated as a candidate packet header. A candidate that fails its field checks is dropped, one word per cycle, until a consistent header reaches the front. For a consistent header, the block waits until the whole packet is in the ring, as given by the header's word count. It then compares the packet's second word against a table of five three-letter ASCII command codes.

A match produces a one-cycle one-hot dispatch pulse. In the same cycle the packet's argument words appear, latched, for downstream logic. Every accepted packet also produces a two-word reply on a valid/ready stream. The reply is a routing header followed by either a completion word, an error word, or the echoed argument of the link-test command. No further packet is processed until both reply words have been taken. Words that arrive while the ring is full are dropped, and a sticky flag records the loss.

Top module: `cmd_packet_checker`

## Requirements
- R1: Received words are stored in a 32-slot ring whose read and write indices wrap modulo 32; occupancy is the write index minus the read index modulo 32, and packet order is kept across the wrap.
- R2: A front word with any bit set under mask 0xFCF0F8 is rejected (source field bits 17:16, destination field bits 11:8, word count bits 2:0; all other bits must be zero).
- R3: A front word whose bits under mask 0x030300 (bits 17:16 and 9:8) are all zero is rejected.
- R4: A front word whose word count (bits 2:0) is zero is rejected.
- R5: A rejection removes exactly one word from the ring in that cycle, and the next word is examined in the following cycle.
- R6: A consistent header is held at the front until occupancy is at least its word count N; the whole packet (N words, header included) is then removed in one cycle.
- R7: The second packet word is matched against ICA=0x494341, RDC=0x524443, TCA=0x544341, TDL=0x54444C, RPT=0x525054, driving dispatch bits [0]..[4] in that order as a single-cycle one-hot pulse one clock after removal; arg_count is N-2 and argument slot i holds packet word i+2 (unused slots zero).
- R8: A matched code other than TDL produces the reply 0x040202 followed by 0x444F4E.
- R9: An unmatched code, or a header with N=1, produces no dispatch and the reply 0x040202 followed by 0x455252.
- R10: TDL produces the reply 0x040002 followed by the third packet word, or zero when N is below 3.
- R11: Each reply word is held stable while reply_valid is high and reply_ready is low; no new header is acted on until the second reply word is accepted.
- R12: When occupancy is 31 at a clock edge, a word offered at that edge is dropped and overflow becomes set and stays set; a removal in the same cycle does not make room for it.
- R13: After reset the ring is empty and dispatch, reply_valid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Incoming word strobe |
| rx_data | input | 24 | Incoming word |
| dispatch | output | 5 | One-hot command pulse (ICA, RDC, TCA, TDL, RPT) |
| arg_count | output | 3 | Number of argument words of the dispatched packet |
| arg_words | output | 120 | Five latched argument slots, slot 0 in the low 24 bits |
| reply_valid | output | 1 | Reply word available |
| reply_ready | input | 1 | Reply word accepted |
| reply_data | output | 24 | Reply word |
| overflow | output | 1 | Sticky flag: a word was dropped on a full ring |

## Verification
Two functions share the ring: writing an incoming word and removing words, whether a rejected header or a whole packet. Both can fall in the same cycle. The sharpest case is a full ring, where a removal and a write to be dropped meet at one edge. To provoke it, the reply stream is stalled until more than 31 words have been offered, then released while words keep streaming in. A behavioural queue model, stepped every clock, decides for each cycle which words survive. Every output is compared against it, so any disagreement over which words were kept shows up later as a wrong dispatch or reply.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    localparam int CNT_W     = 3;
    localparam int MAX_WORDS = (1 << CNT_W) - 1;
    localparam int ARG_SLOTS = MAX_WORDS - 2;
    localparam int NCMD      = 5;
    localparam int TDL_IDX   = 3;

    localparam logic [23:0] HDR_RANGE_MASK = 24'hFCF0F8;
    localparam logic [23:0] HDR_ROUTE_MASK = 24'h030300;
    localparam logic [23:0] RPL_HDR_NORM   = 24'h040202;
    localparam logic [23:0] RPL_HDR_ECHO   = 24'h040002;
    localparam logic [23:0] RPL_WORD_DONE  = 24'h444F4E;
    localparam logic [23:0] RPL_WORD_FAIL  = 24'h455252;

    typedef enum logic [1:0] {
        ST_SCAN     = 2'd0,
        ST_RPL_HDR  = 2'd1,
        ST_RPL_WORD = 2'd2
    } ctl_state_e;

    function automatic logic [23:0] cmd_code(input int idx);
        case (idx)
            0:       return 24'h494341;
            1:       return 24'h524443;
            2:       return 24'h544341;
            3:       return 24'h54444C;
            4:       return 24'h525054;
            default: return 24'h000000;
        endcase
    endfunction

endpackage

// File: rtl/cpc_ring.sv
module cpc_ring #(
    parameter int WORD_W = 24,
    parameter int PTR_W  = 5,
    parameter int WIN    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [PTR_W-1:0]      adv_amt,
    output logic [PTR_W-1:0]      occ,
    output logic                  drop,
    output logic [WIN*WORD_W-1:0] win_words
);
    localparam int DEPTH = 1 << PTR_W;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic full, wr_en;
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        occ   = ptr_q.wr - ptr_q.rd;
        full  = (occ == PTR_W'(DEPTH - 1));
        wr_en = wr_valid && !full;
        drop  = wr_valid && full;
        if (wr_en) ptr_d.wr = ptr_q.wr + 1'b1;
        ptr_d.rd = ptr_q.rd + adv_amt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[ptr_q.wr] <= wr_data;
    end

    for (genvar k = 0; k < WIN; k++) begin : g_win
        logic [PTR_W-1:0] idx;
        assign idx = ptr_q.rd + PTR_W'(k);
        assign win_words[k*WORD_W +: WORD_W] = mem_q[idx];
    end

endmodule

// File: rtl/cpc_hdr_check.sv
module cpc_hdr_check
    import cpc_pkg::*;
(
    input  logic [23:0]      hdr,
    output logic             hdr_ok,
    output logic [CNT_W-1:0] hdr_cnt
);
    logic range_ok, route_ok;

    always_comb begin
        hdr_cnt  = hdr[CNT_W-1:0];
        range_ok = (hdr & HDR_RANGE_MASK) == 24'h0;
        route_ok = (hdr & HDR_ROUTE_MASK) != 24'h0;
        hdr_ok   = range_ok && route_ok && (hdr_cnt != '0);
    end

endmodule

// File: rtl/cpc_cmd_match.sv
module cpc_cmd_match
    import cpc_pkg::*;
(
    input  logic [23:0]     cmd_word,
    output logic [NCMD-1:0] hit
);
    for (genvar i = 0; i < NCMD; i++) begin : g_code
        assign hit[i] = (cmd_word == cmd_code(i));
    end

endmodule

// File: rtl/cmd_packet_checker.sv
module cmd_packet_checker
    import cpc_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int PTR_W  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_valid,
    input  logic [WORD_W-1:0]           rx_data,
    output logic [NCMD-1:0]             dispatch,
    output logic [CNT_W-1:0]            arg_count,
    output logic [ARG_SLOTS*WORD_W-1:0] arg_words,
    output logic                        reply_valid,
    input  logic                        reply_ready,
    output logic [WORD_W-1:0]           reply_data,
    output logic                        overflow
);
    localparam int WIN = MAX_WORDS;

    typedef struct packed {
        ctl_state_e                  st;
        logic [NCMD-1:0]             disp;
        logic [CNT_W-1:0]            argc;
        logic [ARG_SLOTS*WORD_W-1:0] args;
        logic [WORD_W-1:0]           rhdr;
        logic [WORD_W-1:0]           rword;
        logic                        ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PTR_W-1:0]      occ, adv_amt;
    logic                  drop;
    logic [WIN*WORD_W-1:0] win;
    logic                  hdr_ok;
    logic [CNT_W-1:0]      hdr_cnt;
    logic [NCMD-1:0]       hit;
    logic                  known, is_tdl;

    cpc_ring #(.WORD_W(WORD_W), .PTR_W(PTR_W), .WIN(WIN)) ring_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(rx_valid), .wr_data(rx_data),
        .adv_amt(adv_amt), .occ(occ), .drop(drop), .win_words(win)
    );

    cpc_hdr_check hdr_i (
        .hdr(win[0 +: WORD_W]), .hdr_ok(hdr_ok), .hdr_cnt(hdr_cnt)
    );

    cpc_cmd_match match_i (
        .cmd_word(win[WORD_W +: WORD_W]), .hit(hit)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.disp = '0;
        adv_amt    = '0;
        known      = (hdr_cnt >= CNT_W'(2)) && (|hit);
        is_tdl     = known && hit[TDL_IDX];
        if (drop) ctl_d.ovf = 1'b1;
        unique case (ctl_q.st)
            ST_SCAN: begin
                if (occ != '0) begin
                    if (!hdr_ok) begin
                        adv_amt = PTR_W'(1);
                    end else if (occ >= PTR_W'(hdr_cnt)) begin
                        adv_amt    = PTR_W'(hdr_cnt);
                        ctl_d.disp = known ? hit : '0;
                        ctl_d.argc = (hdr_cnt >= CNT_W'(2)) ? CNT_W'(hdr_cnt - CNT_W'(2)) : '0;
                        for (int i = 0; i < ARG_SLOTS; i++) begin
                            if (i + 2 < int'(hdr_cnt))
                                ctl_d.args[i*WORD_W +: WORD_W] = win[(i+2)*WORD_W +: WORD_W];
                            else
                                ctl_d.args[i*WORD_W +: WORD_W] = '0;
                        end
                        ctl_d.rhdr = is_tdl ? RPL_HDR_ECHO : RPL_HDR_NORM;
                        if (!known)
                            ctl_d.rword = RPL_WORD_FAIL;
                        else if (is_tdl)
                            ctl_d.rword = (hdr_cnt >= CNT_W'(3)) ? win[2*WORD_W +: WORD_W] : '0;
                        else
                            ctl_d.rword = RPL_WORD_DONE;
                        ctl_d.st = ST_RPL_HDR;
                    end
                end
            end
            ST_RPL_HDR:  if (reply_ready) ctl_d.st = ST_RPL_WORD;
            ST_RPL_WORD: if (reply_ready) ctl_d.st = ST_SCAN;
            default:     ctl_d.st = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_SCAN;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dispatch    = ctl_q.disp;
    assign arg_count   = ctl_q.argc;
    assign arg_words   = ctl_q.args;
    assign reply_valid = (ctl_q.st != ST_SCAN);
    assign reply_data  = (ctl_q.st == ST_RPL_HDR) ? ctl_q.rhdr : ctl_q.rword;
    assign overflow    = ctl_q.ovf;

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int NCMD   = 5,
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCMD-1:0]   dispatch,
    input logic              reply_valid,
    input logic              reply_ready,
    input logic [WORD_W-1:0] reply_data,
    input logic              overflow
);

    p_reply_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && !reply_ready) |=> (reply_valid && $stable(reply_data)));

    p_dispatch_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dispatch));

    p_dispatch_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch != '0) |=> (dispatch == '0));

    p_dispatch_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch != '0) |-> reply_valid);

    p_overflow_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

bind cmd_packet_checker cpc_checker #(.NCMD(cpc_pkg::NCMD), .WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .dispatch(dispatch), .reply_valid(reply_valid),
    .reply_ready(reply_ready), .reply_data(reply_data), .overflow(overflow)
);

// File: tb/cmd_packet_checker_tb_top.sv
module cmd_packet_checker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rx_valid;
    logic [23:0]  rx_data;
    logic [4:0]   dispatch;
    logic [2:0]   arg_count;
    logic [119:0] arg_words;
    logic         reply_valid;
    logic         reply_ready;
    logic [23:0]  reply_data;
    logic         overflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_packet_checker dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .dispatch(dispatch), .arg_count(arg_count), .arg_words(arg_words),
        .reply_valid(reply_valid), .reply_ready(reply_ready),
        .reply_data(reply_data), .overflow(overflow)
    );

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    int    disp_seen = 0;
    int    rmode = 0;
    string phase_tag = "R13";

    // behavioural reference model
    logic [23:0] mq[$];
    int          mst;
    logic [4:0]  mdisp;
    logic [23:0] mrh, mrw;
    logic [23:0] margs[5];
    int          margc;
    bit          movf;
    string       rkind;

    localparam logic [23:0] C_ICA = 24'h494341, C_RDC = 24'h524443, C_TCA = 24'h544341,
                            C_TDL = 24'h54444C, C_RPT = 24'h525054;

    function automatic int lookup(input logic [23:0] w);
        if (w == C_ICA) return 0;
        if (w == C_RDC) return 1;
        if (w == C_TCA) return 2;
        if (w == C_TDL) return 3;
        if (w == C_RPT) return 4;
        return -1;
    endfunction

    function automatic logic [23:0] mk_hdr(input int src, input int dst, input int n);
        return {6'd0, 2'(src), 4'd0, 4'(dst), 5'd0, 3'(n)};
    endfunction

    task automatic model_reset();
        mq.delete(); mst = 0; mdisp = 0; mrh = 0; mrw = 0; margc = 0; movf = 0;
        for (int i = 0; i < 5; i++) margs[i] = 0;
    endtask

    task automatic model_step();
        bit   full;
        logic [23:0] h;
        int   n, idx;
        full  = (mq.size() == 31);
        mdisp = 0;
        if (rx_valid && full) movf = 1;
        if (mst == 0) begin
            if (mq.size() > 0) begin
                h = mq[0];
                n = int'(h[2:0]);
                if ((h & 24'hFCF0F8) != 0 || (h & 24'h030300) == 0 || n == 0) begin
                    void'(mq.pop_front());
                end else if (mq.size() >= n) begin
                    idx = (n >= 2) ? lookup(mq[1]) : -1;
                    margc = (n >= 2) ? n - 2 : 0;
                    for (int i = 0; i < 5; i++) margs[i] = (i + 2 < n) ? mq[i+2] : 24'h0;
                    if (idx < 0) begin
                        mrh = 24'h040202; mrw = 24'h455252; rkind = "R9";
                    end else if (idx == 3) begin
                        mrh = 24'h040002; mrw = (n >= 3) ? mq[2] : 24'h0; rkind = "R10";
                    end else begin
                        mrh = 24'h040202; mrw = 24'h444F4E; rkind = "R8";
                    end
                    if (idx >= 0) mdisp = 5'(1 << idx);
                    for (int i = 0; i < n; i++) void'(mq.pop_front());
                    mst = 1;
                end
            end
        end else if (mst == 1) begin
            if (reply_ready) mst = 2;
        end else begin
            if (reply_ready) mst = 0;
        end
        if (rx_valid && !full) mq.push_back(rx_data);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare();
        chk(phase_tag, "dispatch", 32'(dispatch), 32'(mdisp));
        chk(phase_tag, "reply_valid", 32'(reply_valid), 32'(mst != 0));
        if (mst != 0)
            chk(rkind, "reply_data", 32'(reply_data), 32'((mst == 1) ? mrh : mrw));
        chk("R12", "overflow", 32'(overflow), 32'(movf));
        if (mdisp != 0) begin
            chk("R7", "arg_count", 32'(arg_count), 32'(margc));
            for (int i = 0; i < 5; i++)
                chk("R7", "arg slot", 32'(arg_words[i*24 +: 24]), 32'(margs[i]));
        end
        if (dispatch != 0) disp_seen++;
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        @(negedge clk);
        compare();
        if (rmode == 0)      reply_ready = 1'b1;
        else if (rmode == 1) reply_ready = 1'($urandom_range(0, 1));
        else                 reply_ready = 1'b0;
        cyc++;
        if (cyc > WATCHDOG) begin
            tests++; fails++;
            $display("FAIL [R11] watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic send(input logic [23:0] w[$], input int gap);
        foreach (w[i]) begin
            rx_valid = 1'b1; rx_data = w[i];
            tick();
            rx_valid = 1'b0;
            repeat (gap) tick();
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            if (mst == 0 && mq.size() == 0) break;
            tick();
        end
        tick();
    endtask

    initial begin
        int d0;
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; reply_ready = 1'b1;
        model_reset();
        repeat (3) tick();
        // R13: reset state
        chk("R13", "dispatch in reset", 32'(dispatch), 0);
        chk("R13", "reply_valid in reset", 32'(reply_valid), 0);
        chk("R13", "overflow in reset", 32'(overflow), 0);
        rst_n = 1'b1;
        tick();

        phase_tag = "R8";
        send('{mk_hdr(1, 2, 2), C_ICA}, 0);
        send('{mk_hdr(2, 1, 7), C_RDC, 24'h11, 24'h22, 24'h33, 24'h44, 24'h55}, 0);
        send('{mk_hdr(3, 0, 2), C_TCA, mk_hdr(0, 3, 3), C_RPT, 24'h777}, 0);
        drain();

        phase_tag = "R10";
        send('{mk_hdr(1, 0, 3), C_TDL, 24'hABCDEF}, 0);
        send('{mk_hdr(1, 0, 2), C_TDL}, 1);
        drain();

        phase_tag = "R9";
        send('{mk_hdr(1, 1, 2), 24'h58595A, mk_hdr(2, 2, 1), mk_hdr(1, 2, 2), C_ICA}, 0);
        drain();

        phase_tag = "R2";
        d0 = disp_seen;
        send('{24'h040102, 24'h01F002, 24'h010109, 24'h800102, mk_hdr(1, 1, 2), C_ICA}, 0);
        drain();
        chk("R5", "dispatches after range rejects", 32'(disp_seen - d0), 1);

        phase_tag = "R3";
        d0 = disp_seen;
        send('{24'h000002, 24'h000402, mk_hdr(0, 1, 2), C_TCA}, 0);
        drain();
        chk("R3", "dispatches after route rejects", 32'(disp_seen - d0), 1);

        phase_tag = "R4";
        d0 = disp_seen;
        send('{24'h010100, 24'h030F00, mk_hdr(1, 0, 2), C_RPT}, 0);
        drain();
        chk("R4", "dispatches after zero-count rejects", 32'(disp_seen - d0), 1);

        phase_tag = "R6";
        send('{mk_hdr(2, 3, 5), C_RDC, 24'hA1, 24'hA2, 24'hA3}, 3);
        drain();

        phase_tag = "R11";
        rmode = 1;
        for (int p = 0; p < 20; p++) begin
            send('{mk_hdr(1, p % 16, 3), (p % 3 == 0) ? C_TDL : C_RDC, 24'(p * 24'h101)}, p % 2);
        end
        drain();
        rmode = 0;

        phase_tag = "R1";
        d0 = disp_seen;
        for (int p = 0; p < 16; p++) send('{mk_hdr(1, 1, 2), C_ICA}, 0);
        drain();
        chk("R1", "dispatches across wrap", 32'(disp_seen - d0), 16);

        phase_tag = "R12";
        send('{mk_hdr(1, 1, 2), C_ICA}, 0);
        rmode = 2;
        tick();
        for (int p = 0; p < 18; p++) send('{mk_hdr(1, 1, 2), C_TCA}, 0);
        chk("R12", "overflow after flood", 32'(overflow), 1);
        rmode = 0;
        for (int p = 0; p < 5; p++) send('{mk_hdr(1, 1, 2), C_ICA}, 0);
        drain();

        phase_tag = "R13";
        rst_n = 1'b0;
        tick();
        chk("R13", "overflow cleared by reset", 32'(overflow), 0);
        rst_n = 1'b1;
        tick();
        send('{mk_hdr(1, 1, 2), C_ICA}, 0);
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule